// File: doc/BRIEF.md
# Non-Restoring Divide Step Unit

This block performs one iteration of a one-bit-per-step non-restoring division. It is the datapath behind a processor's divide-step operation. Each step takes a partial remainder and a divisor from its inputs. The step shifts the remainder left, taking the current T flag into its low bit. It then adds or subtracts the divisor depending on the held Q and M flags. The step records a new Q flag and a new T flag. T holds the quotient bit just produced.

The flags live inside the unit. A load strobe writes all three flags at once to set up a division. For unsigned work all three are cleared. The caller keeps the remainder and feeds it back on every step. It also rotates each T result into its own quotient word. Around the steps, the caller reloads T with the next dividend bit, using the same load strobe with Q and M unchanged. After thirty-two steps and one final rotation, that word holds the quotient.

Top module: `div_step_unit`

## Requirements
- R1: While rst_ni is low and after its release, rem_o is zero, q_o, m_o and t_o are 0 and valid_o is 0, until the first load or step.
- R2: A cycle with init_i high loads q_o, m_o and t_o from init_q_i, init_m_i and init_t_i at the next clock edge. rem_o keeps its value and valid_o stays 0.
- R3: When init_i and step_i are both high, the flag load takes place and the step is dropped. rem_o is unchanged and valid_o stays 0 on the following cycle.
- R4: A cycle with step_i high and init_i low makes valid_o 1 for exactly one cycle after the next edge. In that cycle rem_o equals the shifted value minus dvs_i when the old q_o equals m_o, and the shifted value plus dvs_i otherwise. The shifted value is {rem_i[W-2:0], old t_o}.
- R5: After a step, q_o comes from the old q_o and m_o, the intermediate bit rem_i[W-1] and the carry flag cy. With m_o = 0 (either old q_o), the new q_o is cy when the intermediate bit is 0, and !cy when it is 1. With m_o = 1 (either old q_o), the new q_o is !cy when the intermediate bit is 0, and cy when it is 1.
- R6: After a step, t_o is 1 exactly when the new q_o equals m_o.
- R7: A step never changes m_o.
- R8: In a cycle with neither init_i nor step_i, rem_o, q_o, m_o and t_o hold their values and valid_o is 0 on the next cycle.
- R9: The sequence runs as follows. Load Q = M = T = 0 and start with a remainder of zero. Then, 32 times, rotate the dividend word left with T entering bit 0, load the bit shifted out as T, and step. A final rotation then leaves floor(dividend / divisor) in the word, for any nonzero divisor.
- R10: The carry flag is a borrow on subtraction, defined as the unsigned result being greater than the shifted value. On addition it is defined as the unsigned result being less than the shifted value. A zero divisor therefore gives cy = 0 on both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load strobe for the three flags |
| init_q_i | input | 1 | Q value to load |
| init_m_i | input | 1 | M value to load |
| init_t_i | input | 1 | T value to load |
| step_i | input | 1 | Perform one divide step |
| rem_i | input | W (32) | Partial remainder before the step |
| dvs_i | input | W (32) | Divisor |
| rem_o | output | W (32) | Partial remainder after the last step |
| q_o | output | 1 | Held Q flag |
| m_o | output | 1 | Held M flag |
| t_o | output | 1 | Held T flag (latest quotient bit) |
| valid_o | output | 1 | One-cycle pulse after a step |

## Verification
A wrong add/subtract choice or a wrong carry sense corrupts rem_o in the cycle right after the step. A flawed Q table may look harmless in that step, but it flips the next operation. The remainder then goes wrong one step later, and the quotient bit in T is wrong too. For that reason every step is compared on all outputs, not only at the end of a division. Full unsigned divisions then confirm that no error stays hidden over 32 steps. A T flag that misses the remainder's low bit is caught by stepping with both T values.

// File: rtl/div_step_pkg.sv
package div_step_pkg;
  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } dstep_flags_t;
endpackage

// File: rtl/div_step_shift.sv
module div_step_shift #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic         t_i,
  output logic [W-1:0] shifted_o,
  output logic         msb_o
);
  assign msb_o     = rem_i[W-1];
  assign shifted_o = {rem_i[W-2:0], t_i};
endmodule

// File: rtl/div_step_addsub.sv
module div_step_addsub #(
  parameter int W          = 32,
  parameter bit WIDE_CARRY = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  localparam int WX = W + 1;

  generate
    if (WIDE_CARRY) begin : g_wide
      logic [WX-1:0] ext;
      always_comb begin
        if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i};
        else       ext = {1'b0, a_i} + {1'b0, b_i};
      end
      assign res_o = ext[W-1:0];
      assign cy_o  = ext[W];
    end else begin : g_cmp
      // carry/borrow recovered by comparing the result against the operand
      always_comb begin
        if (sub_i) begin
          res_o = a_i - b_i;
          cy_o  = (res_o > a_i);
        end else begin
          res_o = a_i + b_i;
          cy_o  = (res_o < a_i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/div_step_qsel.sv
module div_step_qsel (
  input  logic old_q_i,
  input  logic m_i,
  input  logic q_mid_i,
  input  logic cy_i,
  output logic q_o,
  output logic t_o
);
  always_comb begin
    unique case ({old_q_i, m_i})
      2'b00, 2'b10: q_o = q_mid_i ? ~cy_i : cy_i;
      2'b01, 2'b11: q_o = q_mid_i ? cy_i : ~cy_i;
      default:      q_o = 1'b0;
    endcase
    t_o = (q_o == m_i);
  end
endmodule

// File: rtl/div_step_unit.sv
module div_step_unit
  import div_step_pkg::*;
#(
  parameter int W          = 32,
  parameter bit WIDE_CARRY = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         init_q_i,
  input  logic         init_m_i,
  input  logic         init_t_i,
  input  logic         step_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dvs_i,
  output logic [W-1:0] rem_o,
  output logic         q_o,
  output logic         m_o,
  output logic         t_o,
  output logic         valid_o
);
  dstep_flags_t flg_q;
  logic [W-1:0] rem_q, shifted, sum;
  logic         q_mid, cy, q_nxt, t_nxt, do_sub, vld_q;

  assign do_sub = (flg_q.q == flg_q.m);

  div_step_shift #(.W(W)) i_shift (
    .rem_i     (rem_i),
    .t_i       (flg_q.t),
    .shifted_o (shifted),
    .msb_o     (q_mid)
  );

  div_step_addsub #(.W(W), .WIDE_CARRY(WIDE_CARRY)) i_addsub (
    .a_i   (shifted),
    .b_i   (dvs_i),
    .sub_i (do_sub),
    .res_o (sum),
    .cy_o  (cy)
  );

  div_step_qsel i_qsel (
    .old_q_i (flg_q.q),
    .m_i     (flg_q.m),
    .q_mid_i (q_mid),
    .cy_i    (cy),
    .q_o     (q_nxt),
    .t_o     (t_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      flg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (init_i) begin
        flg_q <= '{q: init_q_i, m: init_m_i, t: init_t_i};
      end else if (step_i) begin
        rem_q   <= sum;
        flg_q.q <= q_nxt;
        flg_q.t <= t_nxt;
        vld_q   <= 1'b1;
      end
    end
  end

  assign rem_o   = rem_q;
  assign q_o     = flg_q.q;
  assign m_o     = flg_q.m;
  assign t_o     = flg_q.t;
  assign valid_o = vld_q;
endmodule

// File: rtl/div_step_chk.sv
module div_step_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         init_i,
  input logic         init_q_i,
  input logic         init_m_i,
  input logic         init_t_i,
  input logic         step_i,
  input logic [W-1:0] rem_i,
  input logic [W-1:0] dvs_i,
  input logic [W-1:0] rem_o,
  input logic         q_o,
  input logic         m_o,
  input logic         t_o,
  input logic         valid_o
);
  // R2
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (q_o == $past(init_q_i)) && (m_o == $past(init_m_i)) &&
               (t_o == $past(init_t_i)) && $stable(rem_o) && !valid_o);

  // R4
  step_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i) |=> valid_o);

  // R4
  step_rem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i) |=> rem_o == (($past(q_o) == $past(m_o)) ?
      ({$past(rem_i[W-2:0]), $past(t_o)} - $past(dvs_i)) :
      ({$past(rem_i[W-2:0]), $past(t_o)} + $past(dvs_i))));

  // R6
  t_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (t_o == (q_o == m_o)));

  // R7
  m_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !init_i) |=> $stable(m_o));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !init_i) |=> $stable(rem_o) && $stable(q_o) && $stable(m_o) &&
                             $stable(t_o) && !valid_o);
endmodule

bind div_step_unit div_step_chk #(.W(W)) i_div_step_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .init_i  (init_i),
  .init_q_i(init_q_i),
  .init_m_i(init_m_i),
  .init_t_i(init_t_i),
  .step_i  (step_i),
  .rem_i   (rem_i),
  .dvs_i   (dvs_i),
  .rem_o   (rem_o),
  .q_o     (q_o),
  .m_o     (m_o),
  .t_o     (t_o),
  .valid_o (valid_o)
);

// File: tb/test_div_step_unit.sv
`timescale 1ns/1ps
module test_div_step_unit;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] rem;
    logic         q, m, t;
  } exp_t;

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         init_i = 1'b0, init_q_i = 1'b0, init_m_i = 1'b0, init_t_i = 1'b0;
  logic         step_i = 1'b0;
  logic [W-1:0] rem_i = '0, dvs_i = '0;
  logic [W-1:0] rem_o;
  logic         q_o, m_o, t_o, valid_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  exp_t sb[$];
  // bench model of the flags
  logic mq = 0, mm = 0, mt = 0;
  logic [W-1:0] mrem = '0;

  always #10 clk = ~clk;

  div_step_unit #(.W(W)) i_div_step_unit (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .init_q_i(init_q_i),
    .init_m_i(init_m_i), .init_t_i(init_t_i), .step_i(step_i),
    .rem_i(rem_i), .dvs_i(dvs_i), .rem_o(rem_o), .q_o(q_o), .m_o(m_o),
    .t_o(t_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare every step result against the queued expectation
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4 unexpected valid_o", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rem_o == e.rem, "R4/R10 rem_o", rem_o, e.rem);
        chk(q_o == e.q, "R5 q_o", {31'd0, q_o}, {31'd0, e.q});
        chk(t_o == e.t, "R6 t_o", {31'd0, t_o}, {31'd0, e.t});
        chk(m_o == e.m, "R7 m_o", {31'd0, m_o}, {31'd0, e.m});
      end
    end
  end

  task automatic do_init(input logic q, input logic m, input logic t);
    @(negedge clk);
    init_i = 1'b1; init_q_i = q; init_m_i = m; init_t_i = t;
    @(negedge clk);
    init_i = 1'b0;
    mq = q; mm = m; mt = t;
  endtask

  // expected step written from the carry definition in R10
  task automatic do_step(input logic [W-1:0] r, input logic [W-1:0] d);
    logic [W:0] ext;
    logic [W-1:0] s;
    logic c, qmid, nq;
    exp_t e;
    @(negedge clk);
    s = {r[W-2:0], mt};
    qmid = r[W-1];
    if (mq == mm) ext = {1'b0, s} - {1'b0, d};
    else          ext = {1'b0, s} + {1'b0, d};
    c  = ext[W];
    nq = qmid ^ c ^ mm;
    e.rem = ext[W-1:0]; e.q = nq; e.m = mm; e.t = (nq == mm);
    sb.push_back(e);
    mrem = e.rem; mq = e.q; mt = e.t;
    rem_i = r; dvs_i = d; step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic divide(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] lo;
    logic out_bit;
    lo = a;
    do_init(1'b0, 1'b0, 1'b0);
    mrem = '0;
    for (int k = 0; k < W; k++) begin
      out_bit = lo[W-1];
      lo = {lo[W-2:0], mt};
      do_init(mq, mm, out_bit);
      do_step(mrem, b);
    end
    lo = {lo[W-2:0], mt};
    chk(lo == a / b, "R9 quotient", lo, a / b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rem_o == '0 && !q_o && !m_o && !t_o && !valid_o, "R1 in reset",
        {rem_o[27:0], q_o, m_o, t_o, valid_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rem_o == '0 && !q_o && !m_o && !t_o && !valid_o, "R1 after release",
        {rem_o[27:0], q_o, m_o, t_o, valid_o}, '0);

    // R2 flag load
    do_init(1'b1, 1'b0, 1'b1);
    chk({q_o, m_o, t_o} == 3'b101, "R2 flags", {29'd0, q_o, m_o, t_o}, 32'd5);
    chk(rem_o == '0 && !valid_o, "R2 rem held", rem_o, '0);

    // R4 R5 R10: all four {q,m} cases, both intermediate bits
    do_step(32'h8000_0001, 32'h0000_0003);
    do_init(1'b0, 1'b0, 1'b0);
    do_step(32'h0000_0000, 32'h0000_0001);   // borrow path
    do_init(1'b0, 1'b0, 1'b1);
    do_step(32'h4000_0000, 32'h0000_0000);   // R10 zero divisor, no borrow
    do_init(1'b0, 1'b1, 1'b0);
    do_step(32'hFFFF_FFFF, 32'h0000_0002);   // add with carry out
    do_init(1'b1, 1'b1, 1'b1);
    do_step(32'h7FFF_FFFF, 32'hFFFF_FFFF);
    do_init(1'b1, 1'b0, 1'b0);
    do_step(32'hC000_0000, 32'h8000_0000);
    do_init(1'b0, 1'b1, 1'b1);
    do_step(32'h1234_5678, 32'h0000_0000);   // R10 add zero, no carry
    do_step(mrem, 32'h0F0F_0F0F);            // chained step uses updated flags

    // R3 both strobes: load wins, no step
    @(negedge clk);
    init_i = 1'b1; init_q_i = 1'b0; init_m_i = 1'b1; init_t_i = 1'b0;
    step_i = 1'b1; rem_i = 32'hAAAA_AAAA; dvs_i = 32'h1;
    mrem = rem_o;
    @(negedge clk);
    init_i = 1'b0; step_i = 1'b0;
    mq = 1'b0; mm = 1'b1; mt = 1'b0;
    chk(!valid_o, "R3 no valid", {31'd0, valid_o}, '0);
    chk(rem_o == mrem, "R3 rem unchanged", rem_o, mrem);
    chk({q_o, m_o, t_o} == 3'b010, "R3 flags loaded", {29'd0, q_o, m_o, t_o}, 32'd2);

    // R8 idle hold
    repeat (3) @(negedge clk);
    chk(rem_o == mrem && {q_o, m_o, t_o} == 3'b010 && !valid_o, "R8 hold",
        rem_o, mrem);

    // R9 full unsigned divisions
    divide(32'd100, 32'd7);
    divide(32'hFFFF_FFFF, 32'd1);
    divide(32'd5, 32'd9);
    divide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    divide(32'h8000_0000, 32'd3);
    divide(32'd123456789, 32'd1000);
    divide(32'hDEAD_BEEF, 32'h8000_0001);

    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R4 scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule